// File: doc/BRIEF.md
# Multi-Mode 16-Bit Capture/Reload Timer

This block is a 16-bit timer/counter with a companion 16-bit reload register, configured through a small byte-wide register bus. A set of control bits picks one of five operating modes.
- **Auto-reload:** the count restarts from the reload value after it overflows.
- **Capture:** a trigger pin latches the running count into the reload register.
- **Baud-rate generation:** every overflow sends a one-cycle pulse to a serial port.
- **Up/down counting:** the trigger pin level sets the counting direction.
- **Clock output:** a pin toggles on every reload.

The count is advanced by one of two sources, chosen by a counter/timer select bit. In timer selection it follows a base tick enable. In counter selection it follows falling edges on an external count pin. Both external pins are synchronized inside the block before their edges are detected.

Two sticky flags record events: an overflow flag and an external-event flag. Both are readable and writable through the control register, and they share one interrupt request line gated by an enable bit. A reload overflow in baud or clock-out mode produces the serial pulse instead of setting the overflow flag. In those two modes a timer-selected count runs at several steps per base tick.

Top module: `cr_timer16`

## Requirements
- R1: The register map is as follows. All registers reset to zero, and `bus_rdata_o` returns the addressed register combinationally (other addresses read zero).
  - Address 0 is control:
    - bit0 capture select
    - bit1 counter select
    - bit2 run
    - bit3 trigger enable
    - bit4 transmit baud select
    - bit5 receive baud select
    - bit6 external flag
    - bit7 overflow flag
  - Address 1 is mode:
    - bit0 down-count enable
    - bit1 clock-out enable
    - bit2 interrupt enable
  - Addresses 2 and 3 are the count low and high bytes.
  - Addresses 4 and 5 are the reload low and high bytes.
- R2: The operating mode is chosen by the first of these rules that applies:
  1. Clock-out enable selects clock-out mode.
  2. Either baud select selects baud mode.
  3. Capture select selects capture mode.
  4. Down-count enable selects up/down mode.
  5. Otherwise the mode is auto-reload.
- R3: Each pin passes through SYNC_STAGES flops. A falling edge takes effect at the clock edge that follows the cycle in which the synchronized level is first seen low after a high.
- R4: While run is set, the count takes one step per cycle with `tick_i` high (timer selection) or one step per count-pin falling edge (counter selection). With run clear the count holds.
- R5: In auto-reload mode, a step from 0xFFFF loads the reload value and sets the overflow flag.
- R6: In auto-reload mode, a trigger falling edge with trigger enable set loads the reload value and sets the external flag. It takes precedence over a step in the same cycle.
- R7: In capture mode, a trigger falling edge with trigger enable set copies the count held before that cycle's step into the reload register and sets the external flag. The count keeps stepping, and a step from 0xFFFF wraps to zero and sets the overflow flag.
- R8: In baud and clock-out modes, a step from 0xFFFF loads the reload value and drives `ser_pulse_o` high for one cycle, starting at the next clock edge. The overflow flag is untouched. An enabled trigger edge sets only the external flag.
- R9: In baud and clock-out modes with timer selection, each tick adds FAST_MULT steps (6 by default). These are issued one per clock cycle starting the cycle after the tick, and pending steps accumulate up to 2×FAST_MULT.
- R10: In clock-out mode with timer selection, `clk_out_o` toggles on every reload. With counter selection it does not toggle.
- R11: In up/down mode the synchronized trigger level sets the direction: high counts up and low counts down.
  - Counting up, a step from 0xFFFF loads the reload value, sets the overflow flag and toggles the external flag.
  - Counting down, a step whose decremented value (modulo 2^16) is below the reload value loads 0xFFFF, sets the overflow flag and toggles the external flag.
  - Trigger edges do not set the external flag in this mode.
- R12: `irq_o` is high when interrupt enable is set and either the overflow flag is set or the external flag is set outside up/down mode.
- R13: In any cycle where the decoded mode differs from the previous cycle's, or run differs from the previous cycle's, no step is taken, pending fast steps are discarded and a trigger edge is dropped.
- R14: A bus write takes priority over the hardware update of the register it addresses in the same cycle. Writing the control register loads both flags with the written bits 7 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Base tick enable for timer selection |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data of the addressed register |
| cnt_pin_i | input | 1 | External count input (falling edges counted) |
| trig_pin_i | input | 1 | External trigger / direction input |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ext_flag_o | output | 1 | Sticky external flag |
| irq_o | output | 1 | Shared interrupt request |
| ser_pulse_o | output | 1 | One-cycle overflow pulse for a serial port |
| clk_out_o | output | 1 | Toggled clock output |

## Verification
The hardest situations to reach are the coincidences that R13 and R14 govern. Examples are a run toggle that lands in the middle of a burst of fast steps, a mode change in the cycle a trigger edge arrives, and a control write that clears a flag in the same cycle hardware sets it. The bench runs a behavioural model on every clock, so any such collision is judged whenever it occurs. The stimulus creates these collisions on purpose: it toggles run a few cycles after a tick in baud mode, rewrites the mode register while a trigger edge is crossing the synchronizer, and runs a down-count through an underflow just after switching direction.

// File: rtl/cr_timer_pkg.sv
package cr_timer_pkg;

   typedef enum logic [2:0] {
      MD_RELOAD  = 3'd0,
      MD_CAPTURE = 3'd1,
      MD_BAUD    = 3'd2,
      MD_UPDOWN  = 3'd3,
      MD_CLKOUT  = 3'd4
   } cr_mode_e;

   localparam logic [2:0] A_CTRL = 3'd0;
   localparam logic [2:0] A_MODE = 3'd1;
   localparam logic [2:0] A_CNTL = 3'd2;
   localparam logic [2:0] A_CNTH = 3'd3;
   localparam logic [2:0] A_RLDL = 3'd4;
   localparam logic [2:0] A_RLDH = 3'd5;

   // control bit positions
   localparam int B_CAP  = 0;
   localparam int B_CT   = 1;
   localparam int B_RUN  = 2;
   localparam int B_TEN  = 3;
   localparam int B_TXB  = 4;
   localparam int B_RXB  = 5;
   localparam int B_EXTF = 6;
   localparam int B_OVFF = 7;
   // mode register bit positions
   localparam int B_DN   = 0;
   localparam int B_CO   = 1;
   localparam int B_IEN  = 2;

   function automatic cr_mode_e decode_mode(input logic cap, input logic rxb,
                                            input logic txb, input logic dn,
                                            input logic co);
      if (co)
         return MD_CLKOUT;
      else if (rxb || txb)
         return MD_BAUD;
      else if (cap)
         return MD_CAPTURE;
      else if (dn)
         return MD_UPDOWN;
      else
         return MD_RELOAD;
   endfunction

endpackage

// File: rtl/cr_pin_sync.sv
module cr_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cr_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh_q <= '0;
      else
         sh_q <= {sh_q[STAGES-2:0], pin_i};
   end

   assign level_o = sh_q[STAGES-1];

endmodule

// File: rtl/cr_step_gen.sv
module cr_step_gen #(
   parameter int FAST_MULT = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic ct_sel_i,
   input  logic fast_i,
   input  logic tick_i,
   input  logic edge_i,
   input  logic clear_i,
   output logic step_o
);

   generate
      if (FAST_MULT < 1) begin : g_bad_mult
         $error("cr_step_gen: FAST_MULT must be at least 1");
      end
   endgenerate

   localparam int MAXP = 2 * FAST_MULT;
   localparam int PW   = $clog2(MAXP + 1);

   logic [PW-1:0] pend_q;
   logic [PW:0]   sum;
   logic          fast_run;
   logic          busy;

   assign fast_run = fast_i && !ct_sel_i && run_i;
   assign busy     = (pend_q != '0);
   assign sum      = {1'b0, pend_q} + (PW+1)'(FAST_MULT) - {{PW{1'b0}}, busy};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= '0;
      else if (clear_i || !fast_run)
         pend_q <= '0;
      else if (tick_i)
         pend_q <= (sum > (PW+1)'(MAXP)) ? PW'(MAXP) : sum[PW-1:0];
      else if (busy)
         pend_q <= pend_q - PW'(1);
   end

   always_comb begin
      if (!run_i || clear_i)
         step_o = 1'b0;
      else if (ct_sel_i)
         step_o = edge_i;
      else if (fast_i)
         step_o = busy;
      else
         step_o = tick_i;
   end

   // R13: nothing advances in a cycle of mode change or run toggle
   a_r13_no_step_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |-> !step_o);

   // R13: pending burst is discarded after a clear
   a_r13_burst_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (pend_q == '0 || tick_i == 1'b1 || $past(tick_i) == 1'b0));

endmodule

// File: rtl/cr_count_core.sv
module cr_count_core
   import cr_timer_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int CNT_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cr_mode_e          mode_i,
   input  logic              step_i,
   input  logic              trg_i,
   input  logic              dir_up_i,
   input  logic              timer_sel_i,
   input  logic              wr_cnt_lo_i,
   input  logic              wr_cnt_hi_i,
   input  logic              wr_rld_lo_i,
   input  logic              wr_rld_hi_i,
   input  logic              flag_wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [CNT_W-1:0]  rld_o,
   output logic              ovf_o,
   output logic              ext_o,
   output logic              ser_pulse_o,
   output logic              clk_out_o
);

   localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q, cnt_n, rld_q, rld_n, dec;
   logic             ovf_q, ovf_n, ext_q, ext_n, pls_q, pls_n, cko_q, cko_n;
   logic             full;

   assign full = (cnt_q == ALL1);
   assign dec  = cnt_q - CNT_W'(1);

   always_comb begin
      cnt_n = cnt_q;
      rld_n = rld_q;
      ovf_n = ovf_q;
      ext_n = ext_q;
      pls_n = 1'b0;
      cko_n = cko_q;
      case (mode_i)
         MD_RELOAD: begin
            if (trg_i) begin
               cnt_n = rld_q;
               ext_n = 1'b1;
            end else if (step_i) begin
               if (full) begin
                  cnt_n = rld_q;
                  ovf_n = 1'b1;
               end else begin
                  cnt_n = cnt_q + CNT_W'(1);
               end
            end
         end
         MD_CAPTURE: begin
            if (trg_i) begin
               rld_n = cnt_q;
               ext_n = 1'b1;
            end
            if (step_i) begin
               cnt_n = cnt_q + CNT_W'(1);
               if (full)
                  ovf_n = 1'b1;
            end
         end
         MD_BAUD, MD_CLKOUT: begin
            if (trg_i)
               ext_n = 1'b1;
            if (step_i) begin
               if (full) begin
                  cnt_n = rld_q;
                  pls_n = 1'b1;
                  if (mode_i == MD_CLKOUT && timer_sel_i)
                     cko_n = ~cko_q;
               end else begin
                  cnt_n = cnt_q + CNT_W'(1);
               end
            end
         end
         MD_UPDOWN: begin
            if (step_i) begin
               if (dir_up_i) begin
                  if (full) begin
                     cnt_n = rld_q;
                     ovf_n = 1'b1;
                     ext_n = ~ext_q;
                  end else begin
                     cnt_n = cnt_q + CNT_W'(1);
                  end
               end else if (dec < rld_q) begin
                  cnt_n = ALL1;
                  ovf_n = 1'b1;
                  ext_n = ~ext_q;
               end else begin
                  cnt_n = dec;
               end
            end
         end
         default: ;
      endcase
      // bus writes win over hardware updates
      if (wr_cnt_lo_i) cnt_n[DATA_W-1:0]     = wdata_i;
      if (wr_cnt_hi_i) cnt_n[CNT_W-1:DATA_W] = wdata_i;
      if (wr_rld_lo_i) rld_n[DATA_W-1:0]     = wdata_i;
      if (wr_rld_hi_i) rld_n[CNT_W-1:DATA_W] = wdata_i;
      if (flag_wr_i) begin
         ovf_n = wdata_i[B_OVFF];
         ext_n = wdata_i[B_EXTF];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rld_q <= '0;
         ovf_q <= 1'b0;
         ext_q <= 1'b0;
         pls_q <= 1'b0;
         cko_q <= 1'b0;
      end else begin
         cnt_q <= cnt_n;
         rld_q <= rld_n;
         ovf_q <= ovf_n;
         ext_q <= ext_n;
         pls_q <= pls_n;
         cko_q <= cko_n;
      end
   end

   assign cnt_o       = cnt_q;
   assign rld_o       = rld_q;
   assign ovf_o       = ovf_q;
   assign ext_o       = ext_q;
   assign ser_pulse_o = pls_q;
   assign clk_out_o   = cko_q;

   // R5: reload-mode overflow restarts from the reload value and flags it
   a_r5_reload_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MD_RELOAD && step_i && !trg_i && full && !wr_cnt_lo_i &&
       !wr_cnt_hi_i && !flag_wr_i) |=> (cnt_q == $past(rld_q) && ovf_q));

   // R7: capture copies the pre-step count
   a_r7_capture_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MD_CAPTURE && trg_i && !wr_rld_lo_i && !wr_rld_hi_i)
      |=> rld_q == $past(cnt_q));

   // R8: fast modes never touch the overflow flag
   a_r8_no_ovf_fast: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_i == MD_BAUD || mode_i == MD_CLKOUT) && !flag_wr_i) |=> $stable(ovf_q));

   // R11: down-count underflow loads all ones
   a_r11_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MD_UPDOWN && step_i && !dir_up_i && dec < rld_q &&
       !wr_cnt_lo_i && !wr_cnt_hi_i) |=> cnt_q == ALL1);

endmodule

// File: rtl/cr_timer16.sv
module cr_timer16
   import cr_timer_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int FAST_MULT   = 6,
   localparam int CNT_W      = 2 * DATA_W,
   localparam int NPINS      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              bus_wr_i,
   input  logic [2:0]        bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic              cnt_pin_i,
   input  logic              trig_pin_i,
   output logic              ovf_flag_o,
   output logic              ext_flag_o,
   output logic              irq_o,
   output logic              ser_pulse_o,
   output logic              clk_out_o
);

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("cr_timer16: DATA_W must hold the 8 control bits");
      end
   endgenerate

   // ---------------- pin synchronizers and edge detect ----------------
   logic [NPINS-1:0] pin_raw, pin_lvl, pin_last_q, pin_fall;
   assign pin_raw = {trig_pin_i, cnt_pin_i};

   for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
      cr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin_i   (pin_raw[gi]),
         .level_o (pin_lvl[gi])
      );
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pin_last_q[gi] <= 1'b0;
         else
            pin_last_q[gi] <= pin_lvl[gi];
      end
      assign pin_fall[gi] = pin_last_q[gi] & ~pin_lvl[gi];

      // R3: a detected fall lasts exactly one cycle
      a_r3_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
         pin_fall[gi] |=> !pin_fall[gi]);
   end

   // ---------------- register decode ----------------
   logic wr_ctrl, wr_mode, wr_cl, wr_ch, wr_rl, wr_rh;
   assign wr_ctrl = bus_wr_i && (bus_addr_i == A_CTRL);
   assign wr_mode = bus_wr_i && (bus_addr_i == A_MODE);
   assign wr_cl   = bus_wr_i && (bus_addr_i == A_CNTL);
   assign wr_ch   = bus_wr_i && (bus_addr_i == A_CNTH);
   assign wr_rl   = bus_wr_i && (bus_addr_i == A_RLDL);
   assign wr_rh   = bus_wr_i && (bus_addr_i == A_RLDH);

   logic cap_q, ct_q, run_q, ten_q, txb_q, rxb_q;
   logic dn_q, co_q, ien_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {cap_q, ct_q, run_q, ten_q, txb_q, rxb_q} <= '0;
         {dn_q, co_q, ien_q}                       <= '0;
      end else begin
         if (wr_ctrl) begin
            cap_q <= bus_wdata_i[B_CAP];
            ct_q  <= bus_wdata_i[B_CT];
            run_q <= bus_wdata_i[B_RUN];
            ten_q <= bus_wdata_i[B_TEN];
            txb_q <= bus_wdata_i[B_TXB];
            rxb_q <= bus_wdata_i[B_RXB];
         end
         if (wr_mode) begin
            dn_q  <= bus_wdata_i[B_DN];
            co_q  <= bus_wdata_i[B_CO];
            ien_q <= bus_wdata_i[B_IEN];
         end
      end
   end

   // ---------------- mode and change detect ----------------
   cr_mode_e mode, mode_prev_q;
   logic     run_prev_q, clear, fast, trg, step;

   assign mode = decode_mode(cap_q, rxb_q, txb_q, dn_q, co_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_prev_q <= MD_RELOAD;
         run_prev_q  <= 1'b0;
      end else begin
         mode_prev_q <= mode;
         run_prev_q  <= run_q;
      end
   end

   assign clear = (mode != mode_prev_q) || (run_q != run_prev_q);
   assign fast  = (mode == MD_BAUD) || (mode == MD_CLKOUT);
   assign trg   = ten_q && pin_fall[1] && !clear && (mode != MD_UPDOWN);

   cr_step_gen #(.FAST_MULT(FAST_MULT)) u_step (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (run_q),
      .ct_sel_i (ct_q),
      .fast_i   (fast),
      .tick_i   (tick_i),
      .edge_i   (pin_fall[0]),
      .clear_i  (clear),
      .step_o   (step)
   );

   logic [CNT_W-1:0] cnt, rld;
   logic             ovf, ext;

   cr_count_core #(.DATA_W(DATA_W)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (mode),
      .step_i      (step),
      .trg_i       (trg),
      .dir_up_i    (pin_lvl[1]),
      .timer_sel_i (!ct_q),
      .wr_cnt_lo_i (wr_cl),
      .wr_cnt_hi_i (wr_ch),
      .wr_rld_lo_i (wr_rl),
      .wr_rld_hi_i (wr_rh),
      .flag_wr_i   (wr_ctrl),
      .wdata_i     (bus_wdata_i),
      .cnt_o       (cnt),
      .rld_o       (rld),
      .ovf_o       (ovf),
      .ext_o       (ext),
      .ser_pulse_o (ser_pulse_o),
      .clk_out_o   (clk_out_o)
   );

   // ---------------- read mux and outputs ----------------
   always_comb begin
      bus_rdata_o = '0;
      case (bus_addr_i)
         A_CTRL: bus_rdata_o[7:0] = {ovf, ext, rxb_q, txb_q, ten_q, run_q, ct_q, cap_q};
         A_MODE: bus_rdata_o[2:0] = {ien_q, co_q, dn_q};
         A_CNTL: bus_rdata_o      = cnt[DATA_W-1:0];
         A_CNTH: bus_rdata_o      = cnt[CNT_W-1:DATA_W];
         A_RLDL: bus_rdata_o      = rld[DATA_W-1:0];
         A_RLDH: bus_rdata_o      = rld[CNT_W-1:DATA_W];
         default: bus_rdata_o     = '0;
      endcase
   end

   assign ovf_flag_o = ovf;
   assign ext_flag_o = ext;
   assign irq_o      = ien_q && (ovf || (ext && mode != MD_UPDOWN));

   // R2: a set clock-out enable forbids any step from setting the overflow flag
   a_r2_clkout_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (co_q && !wr_ctrl) |=> $stable(ovf));

   // R13: a trigger edge is never taken while the configuration settles
   a_r13_no_trig_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && mode == MD_RELOAD && !wr_ctrl) |=> ext == $past(ext));

endmodule

// File: tb/cr_timer16_test.sv
module cr_timer16_test;

   localparam int SYNC = 2;
   localparam int MULT = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = 3'd2;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       cpin = 1'b1;
   logic       tpin = 1'b1;
   logic       ovf_flag, ext_flag, irq, ser_pulse, clk_out;

   always #5 clk = ~clk;

   cr_timer16 #(.DATA_W(8), .SYNC_STAGES(SYNC), .FAST_MULT(MULT)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick),
      .bus_wr_i    (bus_wr),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .cnt_pin_i   (cpin),
      .trig_pin_i  (tpin),
      .ovf_flag_o  (ovf_flag),
      .ext_flag_o  (ext_flag),
      .irq_o       (irq),
      .ser_pulse_o (ser_pulse),
      .clk_out_o   (clk_out)
   );

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";
   bit    done = 0;

   // ---------------- behavioural reference model ----------------
   int m_cnt, m_rld, m_pend, m_mode_prev;
   bit m_ovf, m_ext, m_pulse, m_cko, m_run_prev;
   bit m_cap, m_ct, m_run, m_ten, m_txb, m_rxb, m_dn, m_co, m_ien;
   bit [SYNC-1:0] m_csh, m_tsh;
   bit m_clast, m_tlast;

   function automatic int mode_of();
      if (m_co) return 4;
      if (m_rxb || m_txb) return 2;
      if (m_cap) return 1;
      if (m_dn) return 3;
      return 0;
   endfunction

   always @(posedge clk) begin : model
      int md, nc, nr, dec, sum;
      bit clr, cf, tf, tl, fast, st, trg, full, pl, old_run;
      if (!rst_n) begin
         m_cnt = 0; m_rld = 0; m_pend = 0; m_mode_prev = 0;
         m_ovf = 0; m_ext = 0; m_pulse = 0; m_cko = 0; m_run_prev = 0;
         {m_cap, m_ct, m_run, m_ten, m_txb, m_rxb, m_dn, m_co, m_ien} = '0;
         m_csh = '0; m_tsh = '0; m_clast = 0; m_tlast = 0;
      end else begin
         md   = mode_of();
         clr  = (md != m_mode_prev) || (m_run != m_run_prev);
         cf   = m_clast && !m_csh[SYNC-1];
         tf   = m_tlast && !m_tsh[SYNC-1];
         tl   = m_tsh[SYNC-1];
         fast = (md == 2) || (md == 4);
         if (!m_run || clr) st = 0;
         else if (m_ct) st = cf;
         else if (fast) st = (m_pend != 0);
         else st = tick;
         trg  = m_ten && tf && !clr && (md != 3);
         full = (m_cnt == 16'hFFFF);
         nc = m_cnt; nr = m_rld; pl = 0;
         case (md)
            0: if (trg) begin nc = m_rld; m_ext = 1; end
               else if (st) begin
                  if (full) begin nc = m_rld; m_ovf = 1; end
                  else nc = m_cnt + 1;
               end
            1: begin
               if (trg) begin nr = m_cnt; m_ext = 1; end
               if (st) begin nc = (m_cnt + 1) & 16'hFFFF; if (full) m_ovf = 1; end
            end
            3: if (st) begin
               if (tl) begin
                  if (full) begin nc = m_rld; m_ovf = 1; m_ext = !m_ext; end
                  else nc = m_cnt + 1;
               end else begin
                  dec = (m_cnt - 1) & 16'hFFFF;
                  if (dec < m_rld) begin nc = 16'hFFFF; m_ovf = 1; m_ext = !m_ext; end
                  else nc = dec;
               end
            end
            default: begin
               if (trg) m_ext = 1;
               if (st) begin
                  if (full) begin
                     nc = m_rld; pl = 1;
                     if (md == 4 && !m_ct) m_cko = !m_cko;
                  end else nc = m_cnt + 1;
               end
            end
         endcase
         // pending fast steps
         if (clr || !(fast && !m_ct && m_run)) m_pend = 0;
         else if (tick) begin
            sum = m_pend + MULT - ((m_pend != 0) ? 1 : 0);
            m_pend = (sum > 2 * MULT) ? 2 * MULT : sum;
         end else if (m_pend != 0) m_pend = m_pend - 1;
         old_run = m_run;
         if (bus_wr) begin
            case (bus_addr)
               3'd0: begin
                  m_cap = bus_wdata[0]; m_ct = bus_wdata[1]; m_run = bus_wdata[2];
                  m_ten = bus_wdata[3]; m_txb = bus_wdata[4]; m_rxb = bus_wdata[5];
                  m_ext = bus_wdata[6]; m_ovf = bus_wdata[7];
               end
               3'd1: begin m_dn = bus_wdata[0]; m_co = bus_wdata[1]; m_ien = bus_wdata[2]; end
               3'd2: nc = (nc & 16'hFF00) | bus_wdata;
               3'd3: nc = (nc & 16'h00FF) | (int'(bus_wdata) << 8);
               3'd4: nr = (nr & 16'hFF00) | bus_wdata;
               3'd5: nr = (nr & 16'h00FF) | (int'(bus_wdata) << 8);
               default: ;
            endcase
         end
         m_cnt = nc; m_rld = nr; m_pulse = pl;
         m_mode_prev = md; m_run_prev = old_run;
         m_clast = m_csh[SYNC-1]; m_tlast = m_tsh[SYNC-1];
         m_csh = {m_csh[SYNC-2:0], cpin};
         m_tsh = {m_tsh[SYNC-2:0], tpin};
      end
   end

   function automatic int exp_read(input logic [2:0] a);
      case (a)
         3'd0: return {m_ovf, m_ext, m_rxb, m_txb, m_ten, m_run, m_ct, m_cap};
         3'd1: return {m_ien, m_co, m_dn};
         3'd2: return m_cnt & 8'hFF;
         3'd3: return (m_cnt >> 8) & 8'hFF;
         3'd4: return m_rld & 8'hFF;
         3'd5: return (m_rld >> 8) & 8'hFF;
         default: return 0;
      endcase
   endfunction

   task automatic chk(input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, got, exp, $time);
      end
   endtask

   // compare every clock, 3 ns after the edge
   always @(posedge clk) begin
      #3;
      if (!done) begin
         chk("rdata", int'(bus_rdata), exp_read(bus_addr));
         chk("ovf_flag", int'(ovf_flag), int'(m_ovf));
         chk("ext_flag", int'(ext_flag), int'(m_ext));
         chk("irq", int'(irq), int'(m_ien && (m_ovf || (m_ext && mode_of() != 3))));
         chk("ser_pulse", int'(ser_pulse), int'(m_pulse));
         chk("clk_out", int'(clk_out), int'(m_cko));
      end
   end

   // ---------------- tick source ----------------
   int tick_per = 0;
   int tick_cnt = 0;
   always @(negedge clk) begin
      tick = (tick_per != 0) && (tick_cnt % ((tick_per != 0) ? tick_per : 1) == 0);
      tick_cnt++;
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 3'd2;
   endtask

   task automatic set_cnt(input int v);
      wr(2, v & 8'hFF); wr(3, (v >> 8) & 8'hFF);
   endtask

   task automatic set_rld(input int v);
      wr(4, v & 8'hFF); wr(5, (v >> 8) & 8'hFF);
   endtask

   task automatic trig_fall(input int low_cycles);
      @(negedge clk); tpin = 1'b0;
      idle(low_cycles);
      tpin = 1'b1;
   endtask

   task automatic cnt_edges(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); cpin = 1'b0;
         idle(2);
         cpin = 1'b1;
         idle(1);
      end
   endtask

   task automatic view_all();
      for (int a = 0; a < 8; a++) begin
         @(negedge clk); bus_addr = 3'(a);
      end
      @(negedge clk); bus_addr = 3'd2;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(1_500_000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual running expected finished");
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // ---------------- test sequence ----------------
   initial begin
      cur_req = "R1";
      idle(3);
      view_all();                       // R1 reset values on every address
      rst_n = 1'b1;
      idle(4);
      set_rld(16'hFFF0);                // R1 register write and read-back
      set_cnt(16'hFFF8);
      view_all();

      cur_req = "R4";                   // R4 run clear: count holds under ticks
      tick_per = 1;
      idle(10);

      cur_req = "R5";                   // R5 reload-mode overflow
      wr(0, 8'h04);
      idle(40);
      tick_per = 3;
      idle(40);

      cur_req = "R14";                  // R14 flag clear by write while running
      wr(0, 8'h04);
      wr(0, 8'hC4);                     // write sets both flags
      wr(0, 8'h04);
      idle(5);

      cur_req = "R6";                   // R6 trigger forces reload
      wr(0, 8'h0C);
      trig_fall(3);
      idle(10);
      view_all();

      cur_req = "R12";                  // R12 interrupt gating
      wr(1, 8'h04);
      idle(5);
      wr(0, 8'h0C);
      idle(5);
      wr(0, 8'h4C);                     // ext only
      idle(3);
      wr(1, 8'h00);
      idle(3);

      cur_req = "R7";                   // R7 capture and wrap
      wr(0, 8'h0D);
      set_cnt(16'hFFE0);
      tick_per = 1;
      idle(6);
      trig_fall(4);
      idle(40);
      view_all();

      cur_req = "R4";                   // R4 counter selection on pin edges
      wr(0, 8'h06);
      tick_per = 1;
      set_cnt(16'hFFFC);
      cnt_edges(8);
      idle(4);

      cur_req = "R8";                   // R8 baud overflow pulses
      set_rld(16'hFFF0);
      wr(0, 8'h14);
      tick_per = 8;
      idle(120);
      wr(0, 8'h1C);
      trig_fall(3);
      idle(20);

      cur_req = "R9";                   // R9 burst steps per tick
      tick_per = 4;                     // pending saturates
      idle(60);
      tick_per = 20;
      idle(60);

      cur_req = "R13";                  // R13 run toggle mid-burst
      tick_per = 0;
      @(negedge clk); tick = 1'b1;
      idle(2);
      wr(0, 8'h10);
      wr(0, 8'h14);
      idle(10);
      wr(0, 8'h0C);                     // back to reload, trigger during mode change
      tpin = 1'b0;
      wr(1, 8'h02);
      tpin = 1'b1;
      wr(1, 8'h00);
      trig_fall(2);
      wr(0, 8'h08);                     // run toggles while edge arrives
      idle(6);

      cur_req = "R10";                  // R10 clock output toggles
      wr(0, 8'h04);
      wr(1, 8'h02);
      set_rld(16'hFFF8);
      tick_per = 6;
      idle(150);
      cur_req = "R10";                  // R10 counter selection: no toggle
      wr(0, 8'h06);
      cnt_edges(12);

      cur_req = "R2";                   // R2 priority: capture + baud behaves as baud
      wr(1, 8'h00);
      wr(0, 8'h25);
      tick_per = 8;
      idle(80);
      wr(0, 8'h05);                     // capture only
      idle(20);
      wr(1, 8'h03);                     // clock-out beats down enable
      wr(0, 8'h04);
      idle(60);

      cur_req = "R11";                  // R11 down count and underflow
      wr(1, 8'h05);
      wr(0, 8'h04);
      set_rld(16'h0010);
      tpin = 1'b0;
      set_cnt(16'h0014);
      tick_per = 1;
      idle(12);
      set_cnt(16'hFFFD);
      tpin = 1'b1;                      // count up through overflow
      idle(12);
      trig_fall(3);                     // edges ignored, direction flips
      idle(10);
      wr(0, 8'h84);
      idle(5);

      cur_req = "R3";                   // R3 short trigger glitches still seen
      wr(1, 8'h00);
      wr(0, 8'h0C);
      trig_fall(1);
      idle(4);
      trig_fall(1);
      idle(6);

      tick_per = 0;
      idle(4);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule